// File: doc/BRIEF.md
# Line Raster-Op Pixel Engine

This block walks a straight line across an 8-bit-per-pixel frame buffer and
writes one pixel per step. Software does all of the slope work ahead of time.
It loads two increment pairs, each holding an address step and an error step.
The engine keeps a running error value and, after each pixel, adds one pair or
the other depending on whether that value is negative. It carries no divider
and no multiplier.

Each pixel is a read-modify-write. The engine reads the destination byte and
combines it with a constant source byte through a 4-bit truth-table code. It
then writes the result back to the same address. A 32-bit pattern, used
cyclically along the line, can suppress individual pixels when pattern gating
is turned on. Configuration goes through a small select/data write port.
Writing the start slot carries the first address and the first error value and
launches the line. A sticky done flag marks the end of the line.

Top module: `line_rop_engine`

## Requirements
- R1: While reset is high and in the cycle after reset, `busy`, `done` and `mem_req` are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the slot named by `cfg_sel`. The slots are:
  - 0: pair used when the error is non-negative. Address step in [15:0], signed error step in [31:16].
  - 1: pair used when the error is negative. Same field layout as slot 0.
  - 2: pixel count in [15:0].
  - 3: logic code in [3:0] and pattern-gating enable in [4].
  - 4: 32-bit pattern.
  - 5: source byte in [7:0].
  - 6: start. First address in [15:0], first signed error in [31:16].
- R3: A start write loads the walk and clears `done`. With a non-zero count, `busy` is 1 from the next cycle. With a count of 0, no memory request is made, `busy` stays 0 and `done` is 1 in the next cycle.
- R4: After each pixel, if the current error is non-negative, both values of slot 0 are added to the address and the error. Otherwise slot 1 is added. Address and error wrap modulo 2^16.
- R5: A line covers exactly `count` pixel steps. After the last one, `busy` falls, `done` rises and no further memory request is made. `mem_req` is never high while `busy` is low, and `done` never coexists with `busy`.
- R6: Every written pixel is a read at its address (`mem_we`=0) followed by a write to the same address (`mem_we`=1). Each phase completes on a cycle where `mem_req` and `mem_ready` are both high.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and, during a write, `mem_wdata` hold their values.
- R8: Each written bit equals bit {s,d} of the logic code, where s is the source bit and d is the read destination bit. For example, code 1100 copies the source, 0110 gives exclusive-or and 1010 keeps the destination.
- R9: With gating enabled, pixel i of the line (counting from 0) is written only if pattern bit (i mod 32) is 1. A gated-off pixel makes no memory request but still advances the address, the error and the count.
- R10: Slot writes, including start, are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_sel | input | 3 | Slot select |
| cfg_wdata | input | 32 | Slot write data |
| busy | output | 1 | Line in progress |
| done | output | 1 | Sticky end-of-line flag, cleared by a start |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for the write phase, 0 for the read phase |
| mem_addr | output | 16 | Pixel byte address |
| mem_wdata | output | 8 | Merged pixel to write |
| mem_rdata | input | 8 | Destination byte returned by memory |
| mem_ready | input | 1 | Memory accepts the current phase |

## Verification
A wrong error sign or a wrong pair selection shows up on `mem_addr` at the
read of the very next pixel. That is at most three cycles after the previous
write completes, plus any stall. A wrong pattern index or count shows up as an
extra or missing memory request, or as `done` rising at the wrong pixel. The
bench tracks all of these as a queue of expected requests compared on every
handshake. A bad merge code or a stale destination byte appears on
`mem_wdata` in the same write handshake. A stall fault shows as an address or
data change while `mem_ready` is low, one cycle later.

// File: rtl/lre_pkg.sv
package lre_pkg;
    localparam int ADDR_W = 16;
    localparam int ERR_W  = 16;
    localparam int CNT_W  = 16;
    localparam int PIX_W  = 8;
    localparam int PAT_W  = 32;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;
    localparam int CODE_W = 4;
    localparam int IDX_W  = $clog2(PAT_W);

    typedef struct packed {
        logic signed [ERR_W-1:0]  err;
        logic        [ADDR_W-1:0] addr;
    } incr_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_INC_POS = 3'd0,
        SEL_INC_NEG = 3'd1,
        SEL_COUNT   = 3'd2,
        SEL_CODE    = 3'd3,
        SEL_PAT     = 3'd4,
        SEL_SRC     = 3'd5,
        SEL_START   = 3'd6
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PIX  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } state_e;

    typedef struct packed {
        incr_t              pos;
        incr_t              neg;
        logic [CNT_W-1:0]   count;
        logic [CODE_W-1:0]  code;
        logic               gate;
        logic [PAT_W-1:0]   pat;
        logic [PIX_W-1:0]   src;
    } cfg_t;

    function automatic logic pat_hit(input logic gate, input logic [PAT_W-1:0] pat,
                                     input logic [IDX_W-1:0] idx);
        return !gate || pat[idx];
    endfunction
endpackage

// File: rtl/lre_regfile.sv
module lre_regfile
    import lre_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     busy,
    output cfg_t                     cfg,
    output logic                     start_go,
    output logic [ADDR_W-1:0]        start_addr,
    output logic signed [ERR_W-1:0]  start_err
);
    logic wr_ok;
    assign wr_ok = we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_ok) begin
            case (sel_e'(sel))
                SEL_INC_POS: cfg.pos   <= incr_t'(wdata[ADDR_W+ERR_W-1:0]);
                SEL_INC_NEG: cfg.neg   <= incr_t'(wdata[ADDR_W+ERR_W-1:0]);
                SEL_COUNT:   cfg.count <= wdata[CNT_W-1:0];
                SEL_CODE: begin
                    cfg.code <= wdata[CODE_W-1:0];
                    cfg.gate <= wdata[CODE_W];
                end
                SEL_PAT:     cfg.pat   <= wdata[PAT_W-1:0];
                SEL_SRC:     cfg.src   <= wdata[PIX_W-1:0];
                default: ;
            endcase
        end
    end

    assign start_go   = wr_ok && (sel_e'(sel) == SEL_START);
    assign start_addr = wdata[ADDR_W-1:0];
    assign start_err  = wdata[ADDR_W +: ERR_W];
endmodule

// File: rtl/lre_walker.sv
module lre_walker #(
    parameter int AW = 16,
    parameter int EW = 16,
    parameter int CW = 16,
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [AW-1:0]        load_addr,
    input  logic signed [EW-1:0] load_err,
    input  logic [CW-1:0]        load_cnt,
    input  logic                 step,
    input  logic [AW-1:0]        pos_addr,
    input  logic signed [EW-1:0] pos_err,
    input  logic [AW-1:0]        neg_addr,
    input  logic signed [EW-1:0] neg_err,
    output logic [AW-1:0]        addr,
    output logic [IW-1:0]        idx,
    output logic                 last
);
    logic signed [EW-1:0] err_q;
    logic [CW-1:0]        cnt_q;
    logic                 err_neg;

    assign err_neg = err_q[EW-1];
    assign last    = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            err_q <= '0;
            cnt_q <= '0;
            idx   <= '0;
        end else if (load) begin
            addr  <= load_addr;
            err_q <= load_err;
            cnt_q <= load_cnt;
            idx   <= '0;
        end else if (step) begin
            if (err_neg) begin
                addr  <= addr + neg_addr;
                err_q <= err_q + neg_err;
            end else begin
                addr  <= addr + pos_addr;
                err_q <= err_q + pos_err;
            end
            cnt_q <= cnt_q - CW'(1);
            idx   <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/lre_rop.sv
module lre_rop #(
    parameter int PW = 8,
    parameter int CODE_BITS = 4
) (
    input  logic [CODE_BITS-1:0] code,
    input  logic [PW-1:0]        src,
    input  logic [PW-1:0]        dst,
    output logic [PW-1:0]        res
);
    for (genvar b = 0; b < PW; b++) begin : g_bit
        assign res[b] = code[{src[b], dst[b]}];
    end
endmodule

// File: rtl/line_rop_engine.sv
module line_rop_engine
    import lre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_ready
);
    cfg_t                    cfg;
    logic                    start_go;
    logic [ADDR_W-1:0]       start_addr;
    logic signed [ERR_W-1:0] start_err;
    state_e                  state;
    logic [PIX_W-1:0]        dst_q;
    logic [ADDR_W-1:0]       cur_addr;
    logic [IDX_W-1:0]        cur_idx;
    logic                    last;
    logic                    pix_en;
    logic                    step;
    logic                    count_zero;

    assign busy       = (state != ST_IDLE);
    assign count_zero = (cfg.count == '0);

    lre_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .busy      (busy),
        .cfg       (cfg),
        .start_go  (start_go),
        .start_addr(start_addr),
        .start_err (start_err)
    );

    lre_walker #(.AW(ADDR_W), .EW(ERR_W), .CW(CNT_W), .IW(IDX_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (start_go && !count_zero),
        .load_addr(start_addr),
        .load_err (start_err),
        .load_cnt (cfg.count),
        .step     (step),
        .pos_addr (cfg.pos.addr),
        .pos_err  (cfg.pos.err),
        .neg_addr (cfg.neg.addr),
        .neg_err  (cfg.neg.err),
        .addr     (cur_addr),
        .idx      (cur_idx),
        .last     (last)
    );

    lre_rop #(.PW(PIX_W), .CODE_BITS(CODE_W)) u_rop (
        .code(cfg.code),
        .src (cfg.src),
        .dst (dst_q),
        .res (mem_wdata)
    );

    assign pix_en = pat_hit(cfg.gate, cfg.pat, cur_idx);
    assign step   = ((state == ST_PIX) && !pix_en) || ((state == ST_WR) && mem_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            dst_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_go) begin
                        done  <= count_zero;
                        state <= count_zero ? ST_IDLE : ST_PIX;
                    end
                end
                ST_PIX: begin
                    if (pix_en) begin
                        state <= ST_RD;
                    end else if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_RD: begin
                    if (mem_ready) begin
                        dst_q <= mem_rdata;
                        state <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_PIX;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (state == ST_RD) || (state == ST_WR);
    assign mem_we   = (state == ST_WR);
    assign mem_addr = cur_addr;
endmodule

// File: rtl/lre_checker.sv
module lre_checker
    import lre_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIX_W-1:0]  mem_wdata
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req));

    p_req_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_read_then_write_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we && $stable(mem_addr)));

    p_write_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ready));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && (!mem_we || $stable(mem_wdata))));
endmodule

bind line_rop_engine lre_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_line_rop_engine.sv
`timescale 1ns/1ps
module sim_line_rop_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    always #10 clk = ~clk;

    line_rop_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int writes_seen = 0;
    int stray = 0;
    bit stall = 1'b0;
    bit rnd_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] mem [0:4095];

    int q_addr[$];
    int q_code[$];
    int q_src[$];

    // bench-side copy of what was written while idle
    logic [15:0] m_pos_a, m_neg_a, m_cnt;
    logic signed [15:0] m_pos_e, m_neg_e;
    logic [3:0]  m_code;
    logic        m_gate;
    logic [31:0] m_pat;
    logic [7:0]  m_src;

    assign mem_rdata = mem[mem_addr[11:0]];

    function automatic logic [7:0] rop_ref(input logic [3:0] c, input logic [7:0] s, input logic [7:0] d);
        return (c[3] ? (s & d) : 8'h00) | (c[2] ? (s & ~d) : 8'h00) |
               (c[1] ? (~s & d) : 8'h00) | (c[0] ? (~s & ~d) : 8'h00);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: ready and handshake observation, away from the rising edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = stall ? 1'b0 : (rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1);
        if (!rst && mem_req && mem_ready) begin
            if (q_addr.size() == 0) begin
                stray++;
                check(1'b0, "R5/R9 unexpected request", int'(mem_addr), 0);
            end else if (!mem_we) begin
                check(int'(mem_addr) == q_addr[0], "R6 read address (R4 walk)", int'(mem_addr), q_addr[0]);
            end else begin
                logic [7:0] exp_d;
                exp_d = rop_ref(q_code[0][3:0], q_src[0][7:0], mem[mem_addr[11:0]]);
                check(int'(mem_addr) == q_addr[0], "R4 write address", int'(mem_addr), q_addr[0]);
                check(mem_wdata == exp_d, "R8 merged data", int'(mem_wdata), int'(exp_d));
                mem[mem_addr[11:0]] = mem_wdata;
                void'(q_addr.pop_front());
                void'(q_code.pop_front());
                void'(q_src.pop_front());
                writes_seen++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cfg_write(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!busy) begin
            case (sel)
                0: begin m_pos_a = data[15:0]; m_pos_e = data[31:16]; end
                1: begin m_neg_a = data[15:0]; m_neg_e = data[31:16]; end
                2: m_cnt = data[15:0];
                3: begin m_code = data[3:0]; m_gate = data[4]; end
                4: m_pat = data;
                5: m_src = data[7:0];
                default: ;
            endcase
        end
    endtask

    // builds the expected request queue from the R4/R9 rules
    function automatic int plan_line(input logic [15:0] a0, input logic signed [15:0] e0);
        logic [15:0] a = a0;
        logic signed [15:0] e = e0;
        int n = 0;
        for (int i = 0; i < int'(m_cnt); i++) begin
            if (!m_gate || m_pat[i % 32]) begin
                q_addr.push_back(int'(a));
                q_code.push_back(int'(m_code));
                q_src.push_back(int'(m_src));
                n++;
            end
            if (e >= 0) begin a = a + m_pos_a; e = e + m_pos_e; end
            else        begin a = a + m_neg_a; e = e + m_neg_e; end
        end
        return n;
    endfunction

    task automatic launch(input logic [15:0] a0, input logic signed [15:0] e0, output int n);
        n = plan_line(a0, e0);
        writes_seen = 0;
        cfg_write(6, {e0, a0});
    endtask

    task automatic finish_line(input int n, input string tag);
        int t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        #1;
        check(done && !busy, {tag, " R5 done/busy at end"}, {busy, done}, 2'b01);
        check(writes_seen == n, {tag, " R5/R9 pixel writes"}, writes_seen, n);
        check(q_addr.size() == 0, {tag, " R5 leftover requests"}, q_addr.size(), 0);
        repeat (3) @(negedge clk);
        #1;
        check(!mem_req && !busy, {tag, " R5 quiet after done"}, {busy, mem_req}, 0);
    endtask

    initial begin
        int n;
        logic [15:0] a_hold;
        logic [7:0] d_hold;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7) ^ 8'h3C;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !mem_req, "R1 reset state", {busy, done, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !done && !mem_req, "R1 after reset", {busy, done, mem_req}, 0);

        // line A: shallow slope, copy, ready always high (R2 R4 R8)
        cfg_write(0, {16'shFFF4, 16'd65});
        cfg_write(1, {16'sd8, 16'd1});
        cfg_write(2, 32'd11);
        cfg_write(3, 32'h0000_000C);
        cfg_write(5, 32'h0000_00C3);
        launch(16'd100, -16'sd2, n);
        #1;
        check(busy && !done, "R3 busy after start", {busy, done}, 2'b10);
        finish_line(n, "lineA R2");

        // line B: gated pattern wraps past 32, xor, random ready (R9 R3)
        rnd_ready = 1'b1;
        cfg_write(0, {16'shFFF6, 16'd63});
        cfg_write(1, {16'sd6, 16'd1});
        cfg_write(2, 32'd40);
        cfg_write(3, 32'h0000_0016);
        cfg_write(4, 32'hA5A5_00FF);
        cfg_write(5, 32'h0000_000F);
        launch(16'd500, 16'sd3, n);
        #1;
        check(!done, "R3 done cleared by start", done, 0);
        finish_line(n, "lineB R9");

        // zero count (R3)
        cfg_write(2, 32'd0);
        launch(16'd7, 16'sd0, n);
        #1;
        check(done && !busy && !mem_req, "R3 zero count", {busy, done, mem_req}, 3'b010);
        check(n == 0, "R3 zero count plan", n, 0);

        // every logic code on a single pixel (R8)
        cfg_write(2, 32'd1);
        cfg_write(5, 32'h0000_005A);
        for (int c = 0; c < 16; c++) begin
            cfg_write(3, 32'(c));
            launch(16'(1000 + c), 16'sd0, n);
            finish_line(n, "R8 code");
        end

        // writes while busy are ignored (R10)
        cfg_write(0, {16'sd1, 16'd2});
        cfg_write(1, {16'sd1, 16'd3});
        cfg_write(2, 32'd6);
        cfg_write(3, 32'h0000_000C);
        cfg_write(5, 32'h0000_0011);
        launch(16'd2000, -16'sd3, n);
        cfg_write(3, 32'h0000_0000);
        cfg_write(5, 32'h0000_00EE);
        cfg_write(6, {16'sd0, 16'd3000});
        finish_line(n, "R10 busy writes");
        launch(16'd2100, -16'sd1, n);
        finish_line(n, "R10 kept config");

        // stall hold and negative address wrap (R7 R4)
        cfg_write(0, {16'shFFFE, 16'hFFFF});
        cfg_write(1, {16'sd1, 16'hFFC0});
        cfg_write(2, 32'd8);
        cfg_write(3, 32'h0000_0006);
        launch(16'd2, 16'sd1, n);
        repeat (4) @(negedge clk);
        @(posedge clk);
        stall = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        a_hold = mem_addr;
        d_hold = mem_wdata;
        repeat (30) @(negedge clk);
        #1;
        check(mem_req && mem_addr == a_hold, "R7 address held in stall", int'(mem_addr), int'(a_hold));
        check(!mem_we || mem_wdata == d_hold, "R7 data held in stall", int'(mem_wdata), int'(d_hold));
        check(busy && !done, "R7 no progress in stall", {busy, done}, 2'b10);
        @(posedge clk);
        stall = 1'b0;
        finish_line(n, "R4 wrap");

        check(stray == 0, "R5 no stray requests", stray, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule